// File: doc/BRIEF.md
# Packet-Framing Queue Tracker

This block tracks packet framing for a multi-queue buffer whose words are 36 bits wide on both sides. Two in-band marker bits in each word mark packet boundaries. Bit 34 set means the word opens a packet. Bit 35 set means the word closes a packet. The tracker watches every accepted write and every accepted read, together with the queue each one addresses. It keeps a count of the closed packets held in each queue. It also remembers, for each queue, whether a packet is still open on the write side. The word storage itself sits outside this block.

On the read side, `pktReady` is high while the queue currently on `rdQueue` holds at least one complete packet. It is meant to be qualified by the storage's own output-valid flag. This lets a consumer wait for a whole frame instead of reacting to any single word that arrives.

Framing mistakes on the write side raise a sticky per-queue error bit. Two cases count as mistakes: a closing marker that arrives with no packet open, and an opening marker that arrives while a packet is already open. Every end-marked word is still counted on both sides, so the counts always match the end-marked words that are actually stored.

Top module: `pkt_track`

## Requirements
- R1: After reset, every queue's packet count is zero, no packet is open, `errFlags` is all zeros, and `pktReady` is low for every value of `rdQueue`.
- R2: An accepted write whose bit 35 is 1 adds one to the packet count of `wrQueue`. From the next cycle, `pktReady` is high while `rdQueue` selects that queue.
- R3: `pktReady` depends only on the count of the queue on `rdQueue`. Packets held in other queues do not raise it.
- R4: An accepted read whose `rdData` bit 35 is 1 subtracts one from the count of `rdQueue`. `pktReady` falls only after the last counted packet of that queue has been read this way, and only a read can lower it.
- R5: A single word with both bit 34 and bit 35 set counts as one complete packet and leaves no packet open.
- R6: A write with bit 34 set and bit 35 clear opens a packet, and `pktReady` stays low until an end-marked word is written.
- R7: An end-marked write (bit 35 = 1, bit 34 = 0) to a queue with no open packet sets `errFlags[wrQueue]`. The word is still counted as a packet.
- R8: A start-marked write to a queue that already has an open packet sets `errFlags[wrQueue]`. The packet restarts at that word, and one end marker then completes exactly one packet.
- R9: Each `errFlags` bit, once set, stays set until reset.
- R10: An end-marked write and an end-marked read in the same cycle on the same queue leave its count unchanged. On different queues, both updates take effect.
- R11: Words presented while `wrEn` or `rdEn` is low change no count, open state or error flag.
- R12: An end-marked read of a queue whose count is zero leaves the count at zero.
- R13: A count at its maximum (2^CNT_W − 1) holds on a further end-marked write, so that exactly that many end-marked reads bring `pktReady` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | A word is accepted into the queue on `wrQueue` this cycle |
| wrQueue | input | QSEL_W | Queue addressed by the write side |
| wrData | input | 36 | Word being written; bit 34 is the start marker, bit 35 the end marker |
| rdEn | input | 1 | A word is taken from the queue on `rdQueue` this cycle |
| rdQueue | input | QSEL_W | Queue selected on the read side |
| rdData | input | 36 | Word being read; bit 35 is the end marker |
| pktReady | output | 1 | The selected read queue holds at least one complete packet |
| errFlags | output | NUM_QUEUES | Sticky framing-error bit for each queue |

## Verification
On every cycle the assertions check four things. Error bits never clear. The two kinds of framing violation set the error bit of the queue written. Start and single-word markers move the open state correctly. `pktReady` can only appear after an end-marked write and can only disappear after a read or a change of selected queue. The exact packet arithmetic can only be shown by the bench's scenarios: several packets draining one by one, a write and a read in the same cycle, saturation at the count limit, and a read of a queue whose count is already zero.

// File: rtl/pkt_track_pkg.sv
package pkt_track_pkg;
  localparam int WORD_W  = 36;
  localparam int START_B = 34;
  localparam int END_B   = 35;

  typedef struct packed {
    logic incPkt;
    logic decPkt;
    logic flagErr;
  } trk_strobe_t;
endpackage

// File: rtl/pkt_track_ctrl.sv
module pkt_track_ctrl
  import pkt_track_pkg::*;
#(
  parameter int NUM_QUEUES = 16,
  parameter int QSEL_W     = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [QSEL_W-1:0]     wrQueue,
  input  logic [WORD_W-1:0]     wrData,
  input  logic                  rdEn,
  input  logic [WORD_W-1:0]     rdData,
  output trk_strobe_t           strobe,
  output logic [NUM_QUEUES-1:0] openVec
);
  logic startMark;
  logic endMark;
  logic curOpen;

  assign startMark = wrData[START_B];
  assign endMark   = wrData[END_B];
  assign curOpen   = openVec[wrQueue];

  always_comb begin
    strobe.incPkt  = wrEn & endMark;
    strobe.decPkt  = rdEn & rdData[END_B];
    strobe.flagErr = wrEn & ((startMark & curOpen) |
                             (endMark & ~startMark & ~curOpen));
  end

  for (genvar q = 0; q < NUM_QUEUES; q++) begin : gOpen
    always_ff @(posedge clk) begin
      if (!rstN) begin
        openVec[q] <= 1'b0;
      end else if (wrEn && (wrQueue == QSEL_W'(q))) begin
        if (endMark)        openVec[q] <= 1'b0;
        else if (startMark) openVec[q] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pkt_track_dp.sv
module pkt_track_dp
  import pkt_track_pkg::*;
#(
  parameter int NUM_QUEUES = 16,
  parameter int QSEL_W     = 4,
  parameter int CNT_W      = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  trk_strobe_t           strobe,
  input  logic [QSEL_W-1:0]     wrQueue,
  input  logic [QSEL_W-1:0]     rdQueue,
  output logic                  pktReady,
  output logic [NUM_QUEUES-1:0] errFlags
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_QUEUES-1:0] haveNz;

  for (genvar q = 0; q < NUM_QUEUES; q++) begin : gCnt
    logic [CNT_W-1:0] pktCnt;
    logic             incHit;
    logic             decHit;

    assign incHit    = strobe.incPkt && (wrQueue == QSEL_W'(q));
    assign decHit    = strobe.decPkt && (rdQueue == QSEL_W'(q));
    assign haveNz[q] = (pktCnt != '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pktCnt <= '0;
      end else if (incHit && !decHit) begin
        if (pktCnt != CNT_MAX) pktCnt <= pktCnt + 1'b1;
      end else if (decHit && !incHit) begin
        if (pktCnt != '0) pktCnt <= pktCnt - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)                                         errFlags[q] <= 1'b0;
      else if (strobe.flagErr && wrQueue == QSEL_W'(q))  errFlags[q] <= 1'b1;
    end
  end

  assign pktReady = haveNz[rdQueue];
endmodule

// File: rtl/pkt_track.sv
module pkt_track
  import pkt_track_pkg::*;
#(
  parameter int NUM_QUEUES = 16,
  parameter int CNT_W      = 12,
  localparam int QSEL_W    = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [QSEL_W-1:0]     wrQueue,
  input  logic [35:0]           wrData,
  input  logic                  rdEn,
  input  logic [QSEL_W-1:0]     rdQueue,
  input  logic [35:0]           rdData,
  output logic                  pktReady,
  output logic [NUM_QUEUES-1:0] errFlags
);
  trk_strobe_t           strobe;
  logic [NUM_QUEUES-1:0] openVec;

  pkt_track_ctrl #(.NUM_QUEUES(NUM_QUEUES), .QSEL_W(QSEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrQueue(wrQueue), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .strobe(strobe), .openVec(openVec)
  );

  pkt_track_dp #(.NUM_QUEUES(NUM_QUEUES), .QSEL_W(QSEL_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrQueue(wrQueue),
    .rdQueue(rdQueue), .pktReady(pktReady), .errFlags(errFlags)
  );
endmodule

// File: rtl/pkt_track_chk.sv
module pkt_track_chk #(
  parameter int NUM_QUEUES = 16,
  parameter int QSEL_W     = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [QSEL_W-1:0]     wrQueue,
  input logic [35:0]           wrData,
  input logic                  rdEn,
  input logic [QSEL_W-1:0]     rdQueue,
  input logic                  pktReady,
  input logic [NUM_QUEUES-1:0] errFlags,
  input logic [NUM_QUEUES-1:0] openVec
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((errFlags & $past(errFlags)) == $past(errFlags))); // R9

  AST_ORPHAN_END: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[35] && !wrData[34] && !openVec[wrQueue])
      |=> errFlags[$past(wrQueue)]); // R7

  AST_RESTART_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[34] && openVec[wrQueue]) |=> errFlags[$past(wrQueue)]); // R8

  AST_SINGLE_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[34] && wrData[35]) |=> !openVec[$past(wrQueue)]); // R5

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[34] && !wrData[35]) |=> openVec[$past(wrQueue)]); // R6

  AST_READY_NEEDS_END: assert property (@(posedge clk) disable iff (!rstN)
    (!pktReady && !(wrEn && wrData[35]))
      |=> (!pktReady || rdQueue != $past(rdQueue))); // R2

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (pktReady && !rdEn) |=> (pktReady || rdQueue != $past(rdQueue))); // R4
endmodule

bind pkt_track pkt_track_chk #(.NUM_QUEUES(NUM_QUEUES), .QSEL_W(QSEL_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrQueue(wrQueue), .wrData(wrData),
  .rdEn(rdEn), .rdQueue(rdQueue), .pktReady(pktReady), .errFlags(errFlags),
  .openVec(openVec)
);

// File: tb/sim_pkt_track.sv
`timescale 1ns/1ps
module sim_pkt_track;
  localparam int NQ = 16;
  localparam int QW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [QW-1:0] wrQueue = '0;
  logic [35:0]   wrData = '0;
  logic          rdEn = 1'b0;
  logic [QW-1:0] rdQueue = '0;
  logic [35:0]   rdData = '0;
  logic          pktReady;
  logic [NQ-1:0] errFlags;

  int vecCnt = 0;
  int missCnt = 0;
  bit doneFlag = 0;

  always #4 clk = ~clk;

  pkt_track #(.NUM_QUEUES(NQ), .CNT_W(3)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrQueue(wrQueue), .wrData(wrData),
    .rdEn(rdEn), .rdQueue(rdQueue), .rdData(rdData),
    .pktReady(pktReady), .errFlags(errFlags)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [35:0] mkWord(bit s, bit e);
    return {e, s, 34'h0_1234_5678};
  endfunction

  task automatic wr(int q, bit s, bit e);
    wrEn = 1'b1; wrQueue = QW'(q); wrData = mkWord(s, e);
    step();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(int q, bit e);
    rdEn = 1'b1; rdQueue = QW'(q); rdData = mkWord(1'b0, e);
    step();
    rdEn = 1'b0; rdData = '0;
  endtask

  task automatic wrRd(int wq, bit ws, bit we, int rq, bit re);
    wrEn = 1'b1; wrQueue = QW'(wq); wrData = mkWord(ws, we);
    rdEn = 1'b1; rdQueue = QW'(rq); rdData = mkWord(1'b0, re);
    step();
    wrEn = 1'b0; rdEn = 1'b0; wrData = '0; rdData = '0;
  endtask

  task automatic chkReady(int q, bit expV, string tag);
    rdQueue = QW'(q);
    #1;
    vecCnt++;
    if (pktReady !== expV) begin
      missCnt++;
      $display("FAIL %s: pktReady q%0d actual %b expected %b", tag, q, pktReady, expV);
    end
  endtask

  task automatic chkErr(logic [NQ-1:0] expV, string tag);
    #1;
    vecCnt++;
    if (errFlags !== expV) begin
      missCnt++;
      $display("FAIL %s: errFlags actual %h expected %h", tag, errFlags, expV);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    step(); step();
    rstN = 1'b1;
  endtask

  task automatic tReset();
    doReset();
    chkErr('0, "R1");
    chkReady(0, 1'b0, "R1");
    chkReady(15, 1'b0, "R1");
  endtask

  task automatic tBasic();
    wr(3, 1, 0);
    chkReady(3, 1'b0, "R6");
    wr(3, 0, 0);
    chkReady(3, 1'b0, "R6");
    wr(3, 0, 1);
    chkReady(3, 1'b1, "R2");
    chkReady(4, 1'b0, "R3");
    rd(3, 0);
    chkReady(3, 1'b1, "R4");
    rd(3, 1);
    chkReady(3, 1'b0, "R4");
  endtask

  task automatic tSingle();
    wr(5, 1, 1);
    chkReady(5, 1'b1, "R5");
    chkErr('0, "R5");
    wr(5, 0, 0);
    chkErr('0, "R5");
    rd(5, 1);
    chkReady(5, 1'b0, "R5");
  endtask

  task automatic tMulti();
    wr(7, 1, 0); wr(7, 0, 1);
    wr(7, 1, 0); wr(7, 0, 1);
    rd(7, 1);
    chkReady(7, 1'b1, "R4");
    rd(7, 1);
    chkReady(7, 1'b0, "R4");
  endtask

  task automatic tEnable();
    wrQueue = QW'(9); wrData = mkWord(1'b1, 1'b1);
    step();
    wrData = '0;
    chkReady(9, 1'b0, "R11");
    chkErr('0, "R11");
    wr(9, 0, 0);
    chkErr('0, "R11");
    wr(7, 1, 1);
    rdQueue = QW'(7); rdData = mkWord(1'b0, 1'b1);
    step();
    rdData = '0;
    chkReady(7, 1'b1, "R11");
    rd(7, 1);
    chkReady(7, 1'b0, "R11");
  endtask

  task automatic tOrphan();
    wr(10, 0, 1);
    chkErr(NQ'(1) << 10, "R7");
    chkReady(10, 1'b1, "R7");
    rd(10, 1);
    chkReady(10, 1'b0, "R7");
    chkErr(NQ'(1) << 10, "R9");
  endtask

  task automatic tRestart();
    wr(11, 1, 0);
    chkErr(NQ'(1) << 10, "R8");
    wr(11, 1, 0);
    chkErr((NQ'(1) << 10) | (NQ'(1) << 11), "R8");
    chkReady(11, 1'b0, "R8");
    wr(11, 0, 1);
    chkReady(11, 1'b1, "R8");
    rd(11, 1);
    chkReady(11, 1'b0, "R8");
  endtask

  task automatic tSimul();
    wr(12, 1, 1);
    wrRd(12, 1, 1, 12, 1);
    chkReady(12, 1'b1, "R10");
    rd(12, 1);
    chkReady(12, 1'b0, "R10");
    wr(13, 1, 1);
    wrRd(14, 1, 1, 13, 1);
    chkReady(13, 1'b0, "R10");
    chkReady(14, 1'b1, "R10");
    rd(14, 1);
    chkReady(14, 1'b0, "R10");
  endtask

  task automatic tUnderflow();
    rd(1, 1);
    chkReady(1, 1'b0, "R12");
    wr(1, 1, 1);
    chkReady(1, 1'b1, "R12");
    rd(1, 1);
    chkReady(1, 1'b0, "R12");
  endtask

  task automatic tSaturate();
    for (int i = 0; i < 8; i++) wr(2, 1, 1);
    chkReady(2, 1'b1, "R13");
    for (int i = 0; i < 6; i++) rd(2, 1);
    chkReady(2, 1'b1, "R13");
    rd(2, 1);
    chkReady(2, 1'b0, "R13");
  endtask

  task automatic tStickyReset();
    wr(6, 1, 1); rd(6, 1);
    chkErr((NQ'(1) << 10) | (NQ'(1) << 11), "R9");
    wr(6, 1, 0);
    doReset();
    chkErr('0, "R1");
    wr(6, 1, 0);
    chkErr('0, "R1");
    chkReady(6, 1'b0, "R1");
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    tReset();
    tBasic();
    tSingle();
    tMulti();
    tEnable();
    tOrphan();
    tRestart();
    tSimul();
    tUnderflow();
    tSaturate();
    tStickyReset();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    vecCnt++;
    missCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule